// File: doc/BRIEF.md
# Time-Aware Gate Scheduler

This block drives the per-queue transmission gates of one egress port from a cyclic, software-programmed schedule. Each schedule entry pairs a gate word with a duration. The gate word has one open/closed bit for each of the eight priority queues and one bit that asks the transmit selector to apply a guardband. The scheduler measures elapsed time on the network-synchronised nanosecond clock, not on local clock cycles. Each entry therefore lasts exactly its programmed duration in synchronised time, however fast or slow the sampling clock runs.

Software programs gate words, durations and the index of the last entry through a single write port, each by entry index. Writes go to a shadow copy of the list. The running schedule picks up the shadow contents only when it starts or wraps back to entry 0, so a cycle never mixes old and new entries. While the scheduler is disabled, every gate stays open and the guardband request stays low.

Top module: `tas_gate_scheduler`

## Requirements
- R1: After reset, and from the clock edge after `enable` is sampled low, `gateOpen` is all ones, `guardEn` is 0 and `curIdx` is 0.
- R2: While running, `guardEn` equals bit 8 of the active entry's gate word, and `gateOpen[k]` equals bit k of that word for k = 0..7. For example, 0x101 gives guardband on and only queue 0 open.
- R3: At the first clock edge where `enable` is sampled high while the scheduler is stopped, the scheduler starts at entry 0. It records the sampled `syncNs` as that entry's start time, and the outputs show entry 0 after that edge.
- R4: An entry with duration field x (x > 0) lasts x × 2048 ns. The index advances at the first edge where `syncNs` minus the entry start is at least x × 2048. The next entry's start is the previous start plus x × 2048, not the sampled time. When time has jumped, the scheduler advances by at most one entry per clock.
- R5: A duration field of 0 behaves exactly like a duration of 1 (2048 ns).
- R6: The list holds last-index + 1 entries. After the entry whose index equals the last index, the scheduler returns to entry 0, and otherwise it moves to the next index.
- R7: Writes to gate words, durations or the last index (cfgSel 0, 1, 2) take effect only when the scheduler starts or returns to entry 0. A write during a cycle leaves the current outputs unchanged.
- R8: Dropping `enable` while running opens all gates, and a later enable restarts from entry 0 at the newly sampled time.
- R9: Gate words (cfgSel = 0, data bits 8:0) and durations (cfgSel = 1, data bits 15:0) are held in separate tables addressed by the same `cfgIdx`. Writing one table never changes the other.
- R10: Elapsed time is computed modulo 2^NS_W, so an entry that spans a rollover of the nanosecond counter keeps its exact duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the schedule. When low, all gates are open |
| syncNs | input | NS_W | Synchronised time in nanoseconds |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | 0 gate word, 1 duration, 2 last index |
| cfgIdx | input | IDX_W | Entry index for gate word and duration writes |
| cfgData | input | CFG_W | Write data |
| gateOpen | output | Q_N | Open gate per queue, bit k for queue k |
| guardEn | output | 1 | Guardband request for the active entry |
| curIdx | output | IDX_W | Index of the active entry |

## Verification
The bench builds the block with NS_W = 20 and keeps the other defaults. With a 20-bit nanosecond counter, a counter rollover can be reached with small time values, so the modulo elapsed-time arithmetic gets checked across a wrap (R10) next to ordinary start, step and wrap points. The 2048 ns unit stays at its default, so each step boundary can be probed one nanosecond early and exactly on time. Time jumps check both the locked start-time accumulation and the one-entry-per-clock catch-up.

// File: rtl/tas_pkg.sv
package tas_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // start: copy shadow list, index 0, capture time
    logic step;   // current entry expired, move on
    logic wrap;   // step from last entry back to 0 (reload shadow)
    logic halt;   // stopped: hold index at 0
  } tasCtl_t;

  typedef enum logic [1:0] {
    SEL_GATE = 2'd0,
    SEL_IVAL = 2'd1,
    SEL_LAST = 2'd2
  } cfgSel_e;
endpackage

// File: rtl/tas_gate_ctrl.sv
module tas_gate_ctrl
  import tas_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    expired,
  input  logic    isLast,
  output tasCtl_t ctl,
  output logic    running
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) running <= 1'b0;
    else       running <= enable;
  end

  always_comb begin
    ctl.load = enable && !running;
    ctl.step = enable && running && expired;
    ctl.wrap = enable && running && expired && isLast;
    ctl.halt = !enable;
  end
endmodule

// File: rtl/tas_gate_datapath.sv
module tas_gate_datapath
  import tas_pkg::*;
#(
  parameter int NS_W    = 48,
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int IV_W    = 16,
  parameter int Q_N     = 8,
  parameter int UNIT_SH = 11,
  parameter int CFG_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NS_W-1:0]  syncNs,
  input  tasCtl_t          ctl,
  input  logic             running,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [CFG_W-1:0] cfgData,
  output logic             expired,
  output logic             isLast,
  output logic [Q_N-1:0]   gateOpen,
  output logic             guardEn,
  output logic [IDX_W-1:0] curIdx
);
  localparam int GW    = Q_N + 1;
  localparam int DUR_W = IV_W + UNIT_SH;
  localparam int CMP_W = (DUR_W > NS_W) ? DUR_W : NS_W;

  logic [GW-1:0]    shState [ENTRIES];
  logic [IV_W-1:0]  shIv    [ENTRIES];
  logic [IDX_W-1:0] shLast;
  logic [GW-1:0]    actState [ENTRIES];
  logic [IV_W-1:0]  actIv    [ENTRIES];
  logic [IDX_W-1:0] actLast;
  logic [NS_W-1:0]  startNs;

  logic [IV_W-1:0]  ivEff;
  logic [DUR_W-1:0] durFull;
  logic [CMP_W-1:0] durCmp;
  logic [NS_W-1:0]  elapsed;
  logic [GW-1:0]    curWord;

  // shadow tables, written by software at any time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        shState[i] <= {1'b0, {Q_N{1'b1}}};
        shIv[i]    <= IV_W'(1);
      end
      shLast <= '0;
    end else if (cfgWe) begin
      case (cfgSel)
        SEL_GATE: if (int'(cfgIdx) < ENTRIES) shState[cfgIdx] <= cfgData[GW-1:0];
        SEL_IVAL: if (int'(cfgIdx) < ENTRIES) shIv[cfgIdx]    <= cfgData[IV_W-1:0];
        SEL_LAST: shLast <= cfgData[IDX_W-1:0];
        default: ;
      endcase
    end
  end

  // active list and sequencing state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        actState[i] <= '0;
        actIv[i]    <= '0;
      end
      actLast <= '0;
      startNs <= '0;
      curIdx  <= '0;
    end else if (ctl.load) begin
      actState <= shState;
      actIv    <= shIv;
      actLast  <= shLast;
      startNs  <= syncNs;
      curIdx   <= '0;
    end else if (ctl.step) begin
      startNs <= startNs + durCmp[NS_W-1:0];
      if (ctl.wrap) begin
        actState <= shState;
        actIv    <= shIv;
        actLast  <= shLast;
        curIdx   <= '0;
      end else begin
        curIdx <= curIdx + 1'b1;
      end
    end else if (ctl.halt) begin
      curIdx <= '0;
    end
  end

  always_comb begin
    ivEff   = (actIv[curIdx] == '0) ? IV_W'(1) : actIv[curIdx];
    durFull = {ivEff, {UNIT_SH{1'b0}}};
    durCmp  = CMP_W'(durFull);
    elapsed = syncNs - startNs;
    expired = CMP_W'(elapsed) >= durCmp;
    isLast  = (curIdx == actLast);
    curWord = actState[curIdx];
    gateOpen = running ? curWord[Q_N-1:0] : {Q_N{1'b1}};
    guardEn  = running && curWord[GW-1];
  end
endmodule

// File: rtl/tas_gate_scheduler.sv
module tas_gate_scheduler
  import tas_pkg::*;
#(
  parameter int NS_W    = 48,
  parameter int ENTRIES = 16,
  parameter int IV_W    = 16,
  parameter int Q_N     = 8,
  parameter int UNIT_SH = 11,
  parameter int CFG_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [NS_W-1:0]  syncNs,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [CFG_W-1:0] cfgData,
  output logic [Q_N-1:0]   gateOpen,
  output logic             guardEn,
  output logic [IDX_W-1:0] curIdx
);
  tasCtl_t ctl;
  logic    running;
  logic    expired;
  logic    isLast;

  tas_gate_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .expired (expired),
    .isLast  (isLast),
    .ctl     (ctl),
    .running (running)
  );

  tas_gate_datapath #(
    .NS_W(NS_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W), .IV_W(IV_W),
    .Q_N(Q_N), .UNIT_SH(UNIT_SH), .CFG_W(CFG_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .syncNs   (syncNs),
    .ctl      (ctl),
    .running  (running),
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .cfgIdx   (cfgIdx),
    .cfgData  (cfgData),
    .expired  (expired),
    .isLast   (isLast),
    .gateOpen (gateOpen),
    .guardEn  (guardEn),
    .curIdx   (curIdx)
  );
endmodule

// File: rtl/tas_gate_checker.sv
module tas_gate_checker #(
  parameter int IDX_W = 4,
  parameter int Q_N   = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [Q_N-1:0]   gateOpen,
  input logic             guardEn,
  input logic [IDX_W-1:0] curIdx
);
  a_r1_stopped_open: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (gateOpen == {Q_N{1'b1}} && !guardEn && curIdx == '0));

  a_r2_guard_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    guardEn |-> $past(enable));

  a_r3_start_entry0: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enable) |=> (curIdx == '0));

  a_r6_index_order: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && curIdx != $past(curIdx))
      |-> (curIdx == '0 || curIdx == IDX_W'($past(curIdx) + 1'b1)));
endmodule

bind tas_gate_scheduler tas_gate_checker #(.IDX_W(IDX_W), .Q_N(Q_N)) u_tasChk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .gateOpen (gateOpen),
  .guardEn  (guardEn),
  .curIdx   (curIdx)
);

// File: tb/test_tas_gate_scheduler.sv
module test_tas_gate_scheduler;
  localparam int NS_W  = 20;
  localparam int IDX_W = 4;

  typedef struct {
    int    idx;
    int    gate;
    int    guard;
    string tag;
  } expItem_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic [NS_W-1:0]  syncNs = '0;
  logic             cfgWe = 1'b0;
  logic [1:0]       cfgSel = '0;
  logic [IDX_W-1:0] cfgIdx = '0;
  logic [15:0]      cfgData = '0;
  logic [7:0]       gateOpen;
  logic             guardEn;
  logic [IDX_W-1:0] curIdx;

  expItem_t expQ[$];
  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tas_gate_scheduler #(.NS_W(NS_W)) i_tas_gate_scheduler (
    .clk(clk), .rstN(rstN), .enable(enable), .syncNs(syncNs),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .gateOpen(gateOpen), .guardEn(guardEn), .curIdx(curIdx)
  );

  // monitor: compare one expected item after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        vectors++;
        if (int'(curIdx) != e.idx || int'(gateOpen) != e.gate || int'(guardEn) != e.guard) begin
          miscompares++;
          $display("FAIL %s: idx/gate/guard actual %0d/%02h/%0d expected %0d/%02h/%0d",
                   e.tag, curIdx, gateOpen, guardEn, e.idx, e.gate, e.guard);
        end
      end
    end
  end

  // drive at a falling edge, expect outputs after the next rising edge
  task automatic tick(input int ns, input int eIdx, input int eGate, input int eGuard, input string tag);
    expItem_t e;
    syncNs = NS_W'(ns);
    e.idx = eIdx; e.gate = eGate; e.guard = eGuard; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic wr(input int sel, input int idx, input int data);
    cfgWe = 1'b1;
    cfgSel = 2'(sel);
    cfgIdx = IDX_W'(idx);
    cfgData = 16'(data);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick(0, 0, 'hFF, 0, "R1 reset state");
    // program while stopped (R9: separate tables, same index)
    wr(0, 0, 'h101); tick(0, 0, 'hFF, 0, "R1 stopped during write");
    wr(1, 0, 2);     tick(0, 0, 'hFF, 0, "R1 stopped during write");
    wr(0, 1, 'h0F0); tick(0, 0, 'hFF, 0, "R1 stopped during write");
    wr(1, 1, 0);     tick(0, 0, 'hFF, 0, "R1 stopped during write");
    wr(0, 2, 'h00A); tick(0, 0, 'hFF, 0, "R1 stopped during write");
    wr(1, 2, 3);     tick(0, 0, 'hFF, 0, "R1 stopped during write");
    wr(2, 0, 2);     tick(0, 0, 'hFF, 0, "R1 stopped during write");
    // start
    enable = 1'b1;
    tick(1000, 0, 'h01, 1, "R3 start entry0 / R2 0x101 mapping");
    tick(5095, 0, 'h01, 1, "R4 one ns early");
    tick(5196, 1, 'hF0, 0, "R4 step to entry1 / R2 mapping");
    tick(7143, 1, 'hF0, 0, "R5 zero interval not yet over");
    tick(7144, 2, 'h0A, 0, "R5 zero interval = 2048 / R4 locked start");
    wr(0, 2, 'h1FF);
    tick(7154, 2, 'h0A, 0, "R7 write mid-cycle ignored");
    tick(13287, 2, 'h0A, 0, "R7 still old word");
    tick(13288, 0, 'h01, 1, "R6 wrap to entry0");
    tick(19432, 1, 'hF0, 0, "R4 catch-up first step");
    tick(19432, 2, 'hFF, 1, "R7 new word after wrap / R4 catch-up");
    tick(19432, 2, 'hFF, 1, "R4 one step per clock");
    // disable and restart
    enable = 1'b0;
    tick(20000, 0, 'hFF, 0, "R8 disable opens gates");
    enable = 1'b1;
    tick(30000, 0, 'h01, 1, "R8 restart entry0");
    wr(2, 0, 0);
    tick(30010, 0, 'h01, 1, "R7 last index write deferred");
    tick(34096, 1, 'hF0, 0, "R7 old length still used");
    tick(36144, 2, 'hFF, 1, "R6 entry2 reached");
    tick(42288, 0, 'h01, 1, "R6 wrap loads length 1");
    tick(46384, 0, 'h01, 1, "R6 single-entry list");
    // rollover of the nanosecond counter
    enable = 1'b0;
    tick(46400, 0, 'hFF, 0, "R8 disable again");
    wr(2, 0, 1); tick(46400, 0, 'hFF, 0, "R1 stopped during write");
    wr(1, 1, 5); tick(46400, 0, 'hFF, 0, "R1 stopped during write");
    enable = 1'b1;
    tick(1047576, 0, 'h01, 1, "R3 start near rollover");
    tick(3095, 0, 'h01, 1, "R10 not early across rollover");
    tick(3096, 1, 'hF0, 0, "R10 step across rollover / R9 word kept");
    tick(13335, 1, 'hF0, 0, "R9 new interval used");
    tick(13336, 0, 'h01, 1, "R6 two-entry wrap");
    @(posedge clk); #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule